// File: doc/BRIEF.md
# Pin-Sensing Interrupt Collector with Capture Lock

This block gathers up to 32 interrupt request lines from peripherals and merges them into one request line towards a processor. Each line is set, at build time, to be sensed on a rising edge or on a high level. A pending flag per line records that the line asked for service. Software reaches four registers over a plain single-cycle register bus: the pending flags, a per-line enable mask, a write-only acknowledge port and a control register.

The control register carries two bits. One is the global output enable. The other, the capture lock, has two effects. While it is set, the lines may change the pending flags and software cannot write them directly. While it is clear, software owns the pending flags and line activity is ignored. A level-sensed line keeps its pending flag set after the line drops. If software acknowledges such a line while it is still high, the flag is set again at once.

Reads are combinational from the addressed register. A write is taken on the clock edge at which select and write are both high. Lines are sampled on every clock edge against a registered copy that is used for edge detection.

Top module: `intr_hub`

## Requirements
- R1: After reset the pending flags, the enable mask and the control register are all zero, `irq_o` is low, and every register reads as zero.
- R2: Byte offset 0x00 holds the pending flags (bit i for line i). A write there replaces the flags only while the capture lock is clear. While the lock is set, such a write changes nothing.
- R3: A level-sensed line's pending flag stays set after the line goes low. Only an acknowledge or a direct write while unlocked clears it.
- R4: While locked, acknowledging a level-sensed line that is still high leaves its pending flag set on the following cycle.
- R5: While locked, an edge-sensed line sets its flag on a clock edge where the line is 1 and its registered copy is 0. The flag stays set until it is acknowledged. A line held high does not set the flag again.
- R6: While the capture lock is clear, line activity changes no pending flag, at the edge or at the level.
- R7: `irq_o` is high exactly when control bit 0 (global enable) is 1 and some pending flag has its enable bit (offset 0x08) set. Clearing only the capture lock does not lower `irq_o`.
- R8: Writing 1 to bit i at offset 0x0C (acknowledge) clears pending flag i. Writing 0 has no effect, and offset 0x0C reads as zero.
- R9: The control register is at offset 0x1C, with bit 0 the global enable and bit 1 the capture lock. Its other bits read as zero, and unmapped offsets read as zero.
- R10: When a line sets its flag in the same cycle as that flag is acknowledged, the set wins and the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC | Interrupt request lines |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | Write strobe (with select) |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data of the addressed register |
| irq_o | output | 1 | Merged interrupt request |

## Verification
Two functions can land on the same clock edge: a line setting its pending flag and software acknowledging that flag. This happens for a level line held high during the acknowledge and for a fresh rising edge driven in the acknowledge cycle. The bench drives the line and the bus write in the same half-cycle, so both are sampled on one edge. A behavioural per-bit model, which applies the acknowledge first and the line set after it, then judges the result on each clock. Directed reads confirm that the flag survives in both cases and clears once the line is low.

// File: rtl/intr_hub_pkg.sv
package intr_hub_pkg;

  // register byte offsets (software-visible map)
  localparam logic [7:0] OFS_PEND = 8'h00;
  localparam logic [7:0] OFS_MASK = 8'h08;
  localparam logic [7:0] OFS_ACK  = 8'h0C;
  localparam logic [7:0] OFS_CTRL = 8'h1C;

  // control register bit positions
  localparam int CTL_GLB  = 0;
  localparam int CTL_LOCK = 1;
  localparam int CTL_W    = 2;

  typedef enum logic [2:0] {
    RSEL_NONE,
    RSEL_PEND,
    RSEL_MASK,
    RSEL_ACK,
    RSEL_CTRL
  } rsel_e;

  typedef struct packed {
    logic pend;
    logic mask;
    logic ack;
    logic ctrl;
  } wr_hit_t;

endpackage

// File: rtl/intr_bus_decode.sv
module intr_bus_decode
  import intr_hub_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wr_hit_t           hit_o,
  output rsel_e             rsel_o
);

  function automatic rsel_e map_offset(input logic [ADDR_W-1:0] a);
    logic [7:0] ofs;
    ofs = 8'(a);
    if (ofs == OFS_PEND)      return RSEL_PEND;
    else if (ofs == OFS_MASK) return RSEL_MASK;
    else if (ofs == OFS_ACK)  return RSEL_ACK;
    else if (ofs == OFS_CTRL) return RSEL_CTRL;
    else                      return RSEL_NONE;
  endfunction

  logic wr_go;

  always_comb begin
    rsel_o = map_offset(addr_i);
    wr_go  = sel_i & wr_i;
    hit_o.pend = wr_go && (rsel_o == RSEL_PEND);
    hit_o.mask = wr_go && (rsel_o == RSEL_MASK);
    hit_o.ack  = wr_go && (rsel_o == RSEL_ACK);
    hit_o.ctrl = wr_go && (rsel_o == RSEL_CTRL);
  end

endmodule

// File: rtl/intr_pin_sense.sv
module intr_pin_sense #(
  parameter int          N_SRC     = 32,
  parameter logic [N_SRC-1:0] EDGE_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic             capture_i,
  output logic [N_SRC-1:0] rise_o,
  output logic [N_SRC-1:0] set_o
);

  logic [N_SRC-1:0] src_q;
  logic [N_SRC-1:0] raw_set;

  // registered copy of every line, used as the edge reference
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_i;
  end

  assign rise_o = src_i & ~src_q;

  // per-line choice of edge or level sensing, fixed by parameter
  for (genvar gi = 0; gi < N_SRC; gi++) begin : g_line
    if (EDGE_MASK[gi]) begin : g_edge
      assign raw_set[gi] = rise_o[gi];
    end else begin : g_level
      assign raw_set[gi] = src_i[gi];
    end
  end

  assign set_o = capture_i ? raw_set : '0;

  // R6: nothing from the lines reaches the flags while capture is off
  p_quiet_unlocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_i |-> (set_o == '0));

endmodule

// File: rtl/intr_state.sv
module intr_state
  import intr_hub_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wr_hit_t          hit_i,
  input  logic [N_SRC-1:0] wdata_i,
  input  logic [CTL_W-1:0] wctl_i,
  input  logic [N_SRC-1:0] set_i,
  output logic [N_SRC-1:0] pend_o,
  output logic [N_SRC-1:0] mask_o,
  output logic [CTL_W-1:0] ctl_o,
  output logic             lock_o,
  output logic             sw_pend_wr_o
);

  logic [N_SRC-1:0] pend_q, pend_d;
  logic [N_SRC-1:0] mask_q;
  logic [CTL_W-1:0] ctl_q;
  logic [N_SRC-1:0] ack_vec;

  // clear first, then let the lines set: a set in the acknowledge cycle wins
  function automatic logic [N_SRC-1:0] next_flags(
    input logic [N_SRC-1:0] cur,
    input logic [N_SRC-1:0] clr,
    input logic [N_SRC-1:0] setv,
    input logic             sw_wr,
    input logic [N_SRC-1:0] sw_val
  );
    logic [N_SRC-1:0] base;
    base = sw_wr ? sw_val : cur;
    return (base & ~clr) | setv;
  endfunction

  assign lock_o       = ctl_q[CTL_LOCK];
  assign sw_pend_wr_o = hit_i.pend & ~lock_o;
  assign ack_vec      = hit_i.ack ? wdata_i : '0;
  assign pend_d       = next_flags(pend_q, ack_vec, set_i, sw_pend_wr_o, wdata_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
      ctl_q  <= '0;
    end else begin
      pend_q <= pend_d;
      if (hit_i.mask) mask_q <= wdata_i;
      if (hit_i.ctrl) ctl_q  <= wctl_i;
    end
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign ctl_o  = ctl_q;

  // R2: a locked direct write can only leave flags that were set or newly raised
  p_locked_write_void_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && hit_i.pend) |=> ((pend_q & ~$past(pend_q | set_i)) == '0));

  // R3: flags fall only through software action
  p_sw_only_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_i.ack || sw_pend_wr_o) |=> (($past(pend_q) & ~pend_q) == '0));

  // R4/R10: a line raising its flag during an acknowledge keeps it set
  p_set_beats_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i.ack && (set_i != '0)) |=> ((~pend_q & $past(set_i)) == '0));

  // R6: unlocked and no direct write -> no flag rises
  p_no_rise_unlocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_o && !hit_i.pend) |=> ((pend_q & ~$past(pend_q)) == '0));

endmodule

// File: rtl/intr_out.sv
module intr_out #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] mask_i,
  input  logic             glb_i,
  output logic             irq_o
);

  function automatic logic any_live(input logic [N_SRC-1:0] p,
                                    input logic [N_SRC-1:0] m);
    return |(p & m);
  endfunction

  assign irq_o = glb_i & any_live(pend_i, mask_i);

  // R7: the request line never rises without the global enable
  p_irq_needs_glb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> glb_i);

endmodule

// File: rtl/intr_hub.sv
module intr_hub
  import intr_hub_pkg::*;
#(
  parameter int               N_SRC     = 32,
  parameter int               ADDR_W    = 5,
  parameter int               DATA_W    = 32,
  parameter logic [N_SRC-1:0] EDGE_MASK = 32'h0000_FF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);

  wr_hit_t          hit;
  rsel_e            rsel;
  logic [N_SRC-1:0] rise_vec;
  logic [N_SRC-1:0] set_vec;
  logic [N_SRC-1:0] pend;
  logic [N_SRC-1:0] mask;
  logic [CTL_W-1:0] ctl;
  logic             lock;
  logic             sw_pend_wr;

  intr_bus_decode #(.ADDR_W(ADDR_W)) i_dec (
    .sel_i (bus_sel_i),
    .wr_i  (bus_wr_i),
    .addr_i(bus_addr_i),
    .hit_o (hit),
    .rsel_o(rsel)
  );

  intr_pin_sense #(.N_SRC(N_SRC), .EDGE_MASK(EDGE_MASK)) i_sense (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_i    (src_i),
    .capture_i(lock),
    .rise_o   (rise_vec),
    .set_o    (set_vec)
  );

  intr_state #(.N_SRC(N_SRC)) i_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .hit_i       (hit),
    .wdata_i     (bus_wdata_i[N_SRC-1:0]),
    .wctl_i      (bus_wdata_i[CTL_W-1:0]),
    .set_i       (set_vec),
    .pend_o      (pend),
    .mask_o      (mask),
    .ctl_o       (ctl),
    .lock_o      (lock),
    .sw_pend_wr_o(sw_pend_wr)
  );

  intr_out #(.N_SRC(N_SRC)) i_out (
    .clk   (clk),
    .rst_n (rst_n),
    .pend_i(pend),
    .mask_i(mask),
    .glb_i (ctl[CTL_GLB]),
    .irq_o (irq_o)
  );

  function automatic logic [DATA_W-1:0] read_mux(
    input rsel_e            s,
    input logic [N_SRC-1:0] p,
    input logic [N_SRC-1:0] m,
    input logic [CTL_W-1:0] c
  );
    case (s)
      RSEL_PEND: return DATA_W'(p);
      RSEL_MASK: return DATA_W'(m);
      RSEL_CTRL: return DATA_W'(c);
      default:   return '0;   // acknowledge port and holes read zero
    endcase
  endfunction

  assign bus_rdata_o = read_mux(rsel, pend, mask, ctl);

  // R7: dropping only the capture lock keeps an active request up
  p_unlock_keeps_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hit.ctrl) && $fell(lock) && ctl[CTL_GLB] && $past(irq_o)) |-> irq_o);

  // R8: the acknowledge port always reads zero
  p_ack_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsel == RSEL_ACK) |-> (bus_rdata_o == '0));

endmodule

// File: tb/test_intr_hub.sv
module test_intr_hub;

  localparam int          N  = 32;
  localparam int          AW = 5;
  localparam int          DW = 32;
  localparam logic [31:0] EM = 32'h0000_FF00;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src = '0;
  logic          sel = 1'b0;
  logic          wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  intr_hub #(.N_SRC(N), .ADDR_W(AW), .DATA_W(DW), .EDGE_MASK(EM)) i_intr_hub (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference model, bit by bit
  logic [31:0] m_pend, m_en, m_prev;
  logic [1:0]  m_ctl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend <= 0; m_en <= 0; m_prev <= 0; m_ctl <= 0;
    end else begin
      logic [31:0] nxt;
      nxt = m_pend;
      if (sel && wr && addr == 5'h00 && !m_ctl[1]) nxt = wdata;
      for (int b = 0; b < N; b++) begin
        if (sel && wr && addr == 5'h0C && wdata[b]) nxt[b] = 1'b0;
        if (m_ctl[1]) begin
          if (EM[b] && src[b] && !m_prev[b]) nxt[b] = 1'b1;
          if (!EM[b] && src[b]) nxt[b] = 1'b1;
        end
      end
      m_pend <= nxt;
      m_prev <= src;
      if (sel && wr && addr == 5'h08) m_en <= wdata;
      if (sel && wr && addr == 5'h1C) m_ctl <= wdata[1:0];
    end
  end

  function automatic logic [31:0] m_read(input logic [AW-1:0] a);
    case (a)
      5'h00:   return m_pend;
      5'h08:   return m_en;
      5'h1C:   return {30'b0, m_ctl};
      default: return 32'b0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare against the model every cycle
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      logic mirq;
      mirq = 1'b0;
      for (int b = 0; b < N; b++) if (m_pend[b] && m_en[b]) mirq = 1'b1;
      chk("R7 model irq", {31'b0, irq}, {31'b0, mirq & m_ctl[0]});
      chk("R9 model read", rdata, m_read(addr));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; wr = 0; wdata = 0;
  endtask

  task automatic check_rd(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
    addr = a;
    #2;
    chk(tag, rdata, exp);
    @(negedge clk);
  endtask

  task automatic check_irq(input string tag, input logic exp);
    #2;
    chk(tag, {31'b0, irq}, {31'b0, exp});
    @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    // R1: reset state
    check_irq("R1 irq after reset", 0);
    check_rd("R1 pend after reset", 5'h00, 0);
    check_rd("R1 mask after reset", 5'h08, 0);
    check_rd("R1 ctrl after reset", 5'h1C, 0);

    // R2/R8: unlocked direct write, acknowledge
    bus_write(5'h00, 32'h5);
    check_rd("R2 unlocked write", 5'h00, 32'h5);
    check_rd("R8 ack reads zero", 5'h0C, 0);
    bus_write(5'h0C, 32'h1);
    check_rd("R8 ack one clears", 5'h00, 32'h4);
    bus_write(5'h0C, 32'h0);
    check_rd("R8 ack zero no effect", 5'h00, 32'h4);
    bus_write(5'h00, 32'h0);
    check_rd("R9 hole reads zero", 5'h04, 0);

    // R6: lines ignored while unlocked
    src[0] = 1; src[8] = 1;
    step(3);
    check_rd("R6 lines ignored unlocked", 5'h00, 0);
    src[0] = 0; src[8] = 0;
    step(1);

    // lock on, global enable on
    bus_write(5'h1C, 32'hFFFF_FFFF);
    check_rd("R9 ctrl bits", 5'h1C, 32'h3);
    bus_write(5'h08, 32'h101);
    bus_write(5'h00, 32'hFFFF);
    check_rd("R2 locked write ignored", 5'h00, 0);

    // R3: level flag held after line drops
    src[0] = 1;
    step(1);
    check_rd("R3 level sets", 5'h00, 32'h1);
    check_irq("R7 irq on enabled flag", 1);
    src[0] = 0;
    step(2);
    check_rd("R3 level holds after drop", 5'h00, 32'h1);
    bus_write(5'h0C, 32'h1);
    check_rd("R8 ack clears low level", 5'h00, 0);

    // R4: ack while level high
    src[0] = 1;
    step(1);
    bus_write(5'h0C, 32'h1);
    check_rd("R4 ack while high retriggers", 5'h00, 32'h1);
    src[0] = 0;
    bus_write(5'h0C, 32'h1);
    check_rd("R4 ack after drop clears", 5'h00, 0);

    // R5: edge source
    src[8] = 1;
    step(1);
    src[8] = 0;
    step(1);
    check_rd("R5 edge sets and holds", 5'h00, 32'h100);
    bus_write(5'h0C, 32'h100);
    check_rd("R5 ack clears edge", 5'h00, 0);
    src[8] = 1;
    step(1);
    bus_write(5'h0C, 32'h100);
    step(2);
    check_rd("R5 held line no reset", 5'h00, 0);
    src[8] = 0;
    step(1);

    // R10: new edge in the acknowledge cycle
    src[9] = 1;
    step(1);
    src[9] = 0;
    step(1);
    src[9] = 1;
    bus_write(5'h0C, 32'h200);
    check_rd("R10 set beats ack", 5'h00, 32'h200);
    src[9] = 0;
    bus_write(5'h0C, 32'h200);
    check_rd("R10 later ack clears", 5'h00, 0);

    // R7: mask and unlock
    src[8] = 1;
    step(1);
    src[8] = 0;
    step(1);
    check_irq("R7 irq from edge flag", 1);
    bus_write(5'h08, 32'h1);
    check_irq("R7 masked flag no irq", 0);
    bus_write(5'h08, 32'h101);
    check_irq("R7 unmasked again", 1);
    bus_write(5'h1C, 32'h1);
    check_irq("R7 unlock keeps irq", 1);
    check_rd("R7 flag kept on unlock", 5'h00, 32'h100);
    bus_write(5'h1C, 32'h0);
    check_irq("R7 global enable off", 0);
    bus_write(5'h00, 32'h0);
    check_rd("R2 unlocked clear", 5'h00, 0);

    step(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule